// File: doc/BRIEF.md
# Narrow-Operand Gated ALU

This block is a 32-bit integer ALU that inspects every operand pair as it is accepted and decides, per operation, whether both values fit in a sign-extendable 16-bit form. When they do, the upper-half operand registers are left unloaded, the upper datapath does no work, and the upper 16 result bits are produced by replicating bit 15 of the lower-half result. A gating-enable output tells the clock network when the upper half may be shut off.

A narrow add or subtract whose 16-bit result does not fit is caught in the execute cycle. The block raises a one-cycle stall, refills the upper operand registers from the sign of the lower ones, and runs the operation again at full width. A separate packing mode treats the two 16-bit halves of each operand as two independent operations. It runs both in the same pass with the carry between halves cut, and returns each half with its own valid bit.

Top module: `narrow_gated_alu`

## Requirements
- R1: An operand is narrow when its bits [31:15] are all zeros or all ones. For a non-packed operation, `upper_gate` is high in the cycle the operation is accepted exactly when both operands are narrow.
- R2: `in_op` selects 000 add, 001 subtract (a minus b), 010 AND, 011 OR, 100 XOR; codes 101 to 111 give a zero result. For a non-packed operation, `out_data` equals the 32-bit wrap-around result whether or not the upper half was gated.
- R3: `out_narrow` is high with a result exactly when the operation ran on the lower half alone. Such a result has bits [31:16] equal to bit 15.
- R4: A gated add or subtract whose true result is not narrow raises `stall` for exactly one cycle, starting the cycle after acceptance. Its full-width result arrives one cycle later than normal, with `out_narrow` low.
- R5: An input presented while `stall` is high is not accepted and produces no result, and `upper_gate` stays low in that cycle.
- R6: With `in_pack` high, bits [15:0] of both operands form lane 0 and bits [31:16] form lane 1. Each lane's 16-bit result wraps on its own with no carry or borrow between lanes. `out_lo_valid` and `out_hi_valid` mark the enabled lanes, `out_narrow` is low and no stall occurs.
- R7: In packed mode, `in_lanes` bit 0 enables lane 0 and bit 1 enables lane 1. A disabled lane returns zero in its half with its valid bit low, and `upper_gate` is high exactly when lane 1 is disabled.
- R8: A result appears on `out_valid` two cycles after its operation is accepted (three when replayed). There is exactly one result per accepted operation, in order.
- R9: While `rst_n` is low at a clock edge, all outputs are low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_pack | input | 1 | Treat the operands as two independent 16-bit lanes |
| in_lanes | input | 2 | Lane enables in packed mode (bit 0 low lane, bit 1 high lane) |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_data | output | 32 | Result |
| out_valid | output | 1 | Result valid |
| out_lo_valid | output | 1 | Packed lane 0 result valid |
| out_hi_valid | output | 1 | Packed lane 1 result valid |
| out_narrow | output | 1 | Result was computed on the lower half only |
| upper_gate | output | 1 | Upper-half registers held this cycle (gating enable) |
| stall | output | 1 | Narrow overflow replay in progress, inputs not accepted |

## Verification
The properties take for granted that `in_valid` is low while reset is held. They also assume nothing upstream counts an input as taken in a cycle where `stall` is high; the latency and bubble properties are written with that rule. The stimulus waits for `stall` to read low before presenting each new operation. During every replay it deliberately drives a live-looking operation, so that an accepted input would show up as an extra result or a raised gate.

// File: rtl/nga_pkg.sv
// Package: shared operation codes for the narrow-operand gated ALU.
// Assumes a 3-bit opcode; codes not listed produce a zero result.
package nga_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    // True for the codes that use the adder.
    function automatic logic is_arith(input logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/nga_width_detect.sv
// Module: decides whether a full-width operand is a sign-extendable
// narrow value. Assumes NW <= DW; the top DW-NW+1 bits must all agree.
module nga_width_detect #(
    parameter int DW = 32,
    parameter int NW = 16
) (
    input  logic [DW-1:0] val,
    output logic          narrow
);
    localparam int TOP_BITS = DW - NW + 1;

    logic [TOP_BITS-1:0] top_part;

    // Flag the operand narrow when its upper bits are all copies of the sign.
    always_comb begin
        top_part = val[DW-1:NW-1];
        narrow   = (&top_part) | ~(|top_part);
    end
endmodule

// File: rtl/nga_lane.sv
// Module: one W-bit ALU slice. The carry-in is supplied by the caller so
// slices can be chained (full width) or isolated (packed). Subtraction
// inverts b here; the caller supplies cin = 1 for the lowest slice.
module nga_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    input  logic         cin,
    output logic [W-1:0] y
);
    import nga_pkg::*;

    logic [W-1:0] b_eff;
    logic [W-1:0] sum;

    // Adder path shared by add and subtract.
    always_comb begin
        b_eff = (op == OP_SUB) ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, cin};
    end

    // Select the slice result by operation code.
    always_comb begin
        case (alu_op_e'(op))
            OP_ADD, OP_SUB: y = sum;
            OP_AND:         y = a & b;
            OP_OR:          y = a | b;
            OP_XOR:         y = a ^ b;
            default:        y = '0;
        endcase
    end
endmodule

// File: rtl/nga_half_reg.sv
// Module: one half-width operand register with a load enable. When the
// enable is low the register holds, which is the gating point for the
// half it feeds. Synchronous active-low reset.
module nga_half_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on enable, otherwise hold the previous operand.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/narrow_gated_alu.sv
// Module: narrow-operand gated ALU top.
// Stage 1 registers the operands split into two halves; the upper half
// is not loaded when both operands are narrow (or the packed upper lane
// is off). Stage 2 computes and registers the result. A gated add or
// subtract that overflows 16 bits is replayed once at full width, with
// the upper registers refilled from the lower-half sign bits.
// Assumes the source holds off new work while stall is high.
module narrow_gated_alu #(
    parameter int  LANE_W = 16,
    localparam int DW     = 2 * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_pack,
    input  logic [1:0]    in_lanes,
    input  logic [2:0]    in_op,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          out_lo_valid,
    output logic          out_hi_valid,
    output logic          out_narrow,
    output logic          upper_gate,
    output logic          stall
);
    import nga_pkg::*;

    localparam int NLANE = 2;
    localparam int MSB   = LANE_W - 1;

    logic              a_narrow, b_narrow;
    logic              accept, lo_load, hi_load;

    logic              half_en [NLANE];
    logic [LANE_W-1:0] half_a_d [NLANE];
    logic [LANE_W-1:0] half_b_d [NLANE];
    logic [LANE_W-1:0] half_a_q [NLANE];
    logic [LANE_W-1:0] half_b_q [NLANE];
    logic              lane_cin [NLANE];
    logic [LANE_W-1:0] lane_y   [NLANE];

    logic              st_vld, st_pack, st_narrow;
    logic [1:0]        st_lanes;
    logic [2:0]        st_op;

    logic              lo_b_eff_msb, lo_cout, lo_ovf, fire;
    logic [DW-1:0]     result;

    // Width checks on the incoming operands.
    nga_width_detect #(.DW(DW), .NW(LANE_W)) u_det_a (.val(in_a), .narrow(a_narrow));
    nga_width_detect #(.DW(DW), .NW(LANE_W)) u_det_b (.val(in_b), .narrow(b_narrow));

    // Acceptance, gating decision and register load enables.
    always_comb begin
        accept     = in_valid & ~stall;
        upper_gate = accept & (in_pack ? ~in_lanes[1] : (a_narrow & b_narrow));
        lo_load    = accept & ~(in_pack & ~in_lanes[0]);
        hi_load    = (accept & ~upper_gate) | stall;
    end

    // Operand half inputs; on replay the upper half is rebuilt from the sign.
    always_comb begin
        half_en[0]  = lo_load;
        half_en[1]  = hi_load;
        half_a_d[0] = in_a[LANE_W-1:0];
        half_b_d[0] = in_b[LANE_W-1:0];
        half_a_d[1] = stall ? {LANE_W{half_a_q[0][MSB]}} : in_a[DW-1:LANE_W];
        half_b_d[1] = stall ? {LANE_W{half_b_q[0][MSB]}} : in_b[DW-1:LANE_W];
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_half
        nga_half_reg #(.W(LANE_W)) u_ra (
            .clk(clk), .rst_n(rst_n), .en(half_en[g]),
            .d(half_a_d[g]), .q(half_a_q[g])
        );
        nga_half_reg #(.W(LANE_W)) u_rb (
            .clk(clk), .rst_n(rst_n), .en(half_en[g]),
            .d(half_b_d[g]), .q(half_b_q[g])
        );
        nga_lane #(.W(LANE_W)) u_lane (
            .a(half_a_q[g]), .b(half_b_q[g]), .op(st_op),
            .cin(lane_cin[g]), .y(lane_y[g])
        );
    end

    // Stage-1 control: capture on accept, drop the narrow mark on replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld    <= 1'b0;
            st_pack   <= 1'b0;
            st_narrow <= 1'b0;
            st_lanes  <= '0;
            st_op     <= '0;
        end else if (stall) begin
            st_narrow <= 1'b0;
        end else begin
            st_vld <= accept;
            if (accept) begin
                st_op     <= in_op;
                st_pack   <= in_pack;
                st_lanes  <= in_lanes;
                st_narrow <= ~in_pack & a_narrow & b_narrow;
            end
        end
    end

    // Lower-lane carry out and signed overflow, rebuilt from the MSB column.
    always_comb begin
        lo_b_eff_msb = (st_op == OP_SUB) ? ~half_b_q[0][MSB] : half_b_q[0][MSB];
        lo_cout      = (half_a_q[0][MSB] & lo_b_eff_msb)
                     | ((half_a_q[0][MSB] ^ lo_b_eff_msb) & ~lane_y[0][MSB]);
        lo_ovf       = (half_a_q[0][MSB] == lo_b_eff_msb)
                     & (lane_y[0][MSB] != half_a_q[0][MSB]);
        lane_cin[0]  = (st_op == OP_SUB);
        lane_cin[1]  = st_pack ? (st_op == OP_SUB) : lo_cout;
    end

    // Replay request and final result selection.
    always_comb begin
        stall = st_vld & st_narrow & is_arith(st_op) & lo_ovf;
        fire  = st_vld & ~stall;
        if (st_pack)
            result = {st_lanes[1] ? lane_y[1] : '0, st_lanes[0] ? lane_y[0] : '0};
        else if (st_narrow)
            result = {{LANE_W{lane_y[0][MSB]}}, lane_y[0]};
        else
            result = {lane_y[1], lane_y[0]};
    end

    // Stage-2 output register; flags are cleared when no result is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data     <= '0;
            out_valid    <= 1'b0;
            out_narrow   <= 1'b0;
            out_lo_valid <= 1'b0;
            out_hi_valid <= 1'b0;
        end else begin
            out_valid    <= fire;
            out_narrow   <= fire & st_narrow;
            out_lo_valid <= fire & st_pack & st_lanes[0];
            out_hi_valid <= fire & st_pack & st_lanes[1];
            if (fire) out_data <= result;
        end
    end
endmodule

// File: rtl/nga_checker.sv
// Module: property checker for narrow_gated_alu, attached by bind.
// Assumes in_valid is low while reset is held.
module nga_checker #(
    parameter int  LANE_W = 16,
    localparam int DW     = 2 * LANE_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          stall,
    input logic          upper_gate,
    input logic          out_valid,
    input logic          out_narrow,
    input logic          out_lo_valid,
    input logic          out_hi_valid,
    input logic [DW-1:0] out_data
);
    // R1: the upper half is only gated for an operation being taken.
    assert_gate_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        upper_gate |-> (in_valid && !stall));

    // R3: a lower-half-only result is sign extended.
    assert_narrow_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_narrow) |-> (out_data[DW-1:LANE_W] == {LANE_W{out_data[LANE_W-1]}}));

    // R4: a replay lasts one cycle and leaves a bubble behind it.
    assert_stall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    assert_stall_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !out_valid);

    // R6: lane valid bits only accompany a non-narrow result.
    assert_lane_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_lo_valid || out_hi_valid) |-> (out_valid && !out_narrow));

    // R7: with only the low lane enabled, the upper half reads zero.
    assert_lane_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_lo_valid && !out_hi_valid) |-> (out_data[DW-1:LANE_W] == '0));

    // R8: every result traces back to an acceptance or a replay two cycles earlier.
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid && !stall, 2) || $past(stall, 2)));

    // R9: reset clears the result and replay outputs.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_narrow && !out_lo_valid && !out_hi_valid && !stall));
endmodule

bind narrow_gated_alu nga_checker #(.LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stall(stall),
    .upper_gate(upper_gate), .out_valid(out_valid), .out_narrow(out_narrow),
    .out_lo_valid(out_lo_valid), .out_hi_valid(out_hi_valid), .out_data(out_data)
);

// File: tb/sim_narrow_gated_alu.sv
// Bench: scoreboard for narrow_gated_alu. The driver task computes the
// expected result from the requirements and queues it; a monitor pops and
// compares on every valid result.
module sim_narrow_gated_alu;
    localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, AND_ = 3'd2, OR_ = 3'd3, XOR_ = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_pack;
    logic [1:0]  in_lanes;
    logic [2:0]  in_op;
    logic [31:0] in_a, in_b;
    logic [31:0] out_data;
    logic        out_valid, out_lo_valid, out_hi_valid, out_narrow, upper_gate, stall;

    int checks = 0;
    int fails  = 0;
    logic [34:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    narrow_gated_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pack(in_pack),
        .in_lanes(in_lanes), .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .out_data(out_data), .out_valid(out_valid), .out_lo_valid(out_lo_valid),
        .out_hi_valid(out_hi_valid), .out_narrow(out_narrow),
        .upper_gate(upper_gate), .stall(stall)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref32(input logic [2:0] op, input logic [31:0] a, b);
        case (op)
            3'd0:    return a + b;
            3'd1:    return a - b;
            3'd2:    return a & b;
            3'd3:    return a | b;
            3'd4:    return a ^ b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] ref16(input logic [2:0] op, input logic [15:0] a, b);
        logic [31:0] w;
        w = ref32(op, {16'h0, a}, {16'h0, b});
        return w[15:0];
    endfunction

    function automatic bit fits16(input logic [31:0] v);
        return (v[31:15] == 17'h0) || (v[31:15] == 17'h1FFFF);
    endfunction

    // Drive one operation at a falling edge, queue its expected result.
    task automatic send(input logic [31:0] a, b, input logic [2:0] op,
                        input logic pk, input logic [1:0] ln, input string tag);
        logic [31:0] r;
        bit          g, ovf, gate_exp;
        if (!pk) begin
            r   = ref32(op, a, b);
            g   = fits16(a) && fits16(b);
            ovf = g && (op <= 3'd1) && !fits16(r);
            exp_q.push_back({r, g && !ovf, 2'b00});
            gate_exp = g;
        end else begin
            r[15:0]  = ln[0] ? ref16(op, a[15:0], b[15:0]) : 16'h0;
            r[31:16] = ln[1] ? ref16(op, a[31:16], b[31:16]) : 16'h0;
            ovf = 1'b0;
            exp_q.push_back({r, 1'b0, ln[1], ln[0]});
            gate_exp = !ln[1];
        end
        tag_q.push_back(tag);
        in_valid = 1'b1; in_pack = pk; in_lanes = ln; in_op = op; in_a = a; in_b = b;
        #1;
        chk(upper_gate == gate_exp, pk ? "R7" : "R1", "upper_gate", 35'(upper_gate), 35'(gate_exp));
        @(negedge clk);
        in_valid = 1'b0;
        chk(stall == ovf, "R4", "stall after accept", 35'(stall), 35'(ovf));
        if (ovf) begin
            // R5: a live-looking operation during the replay must be ignored.
            in_valid = 1'b1; in_pack = 1'b0; in_op = ADD;
            in_a = 32'h0000_0042; in_b = 32'h0000_0011;
            #1;
            chk(upper_gate == 1'b0, "R5", "gate during stall", 35'(upper_gate), 35'(0));
            @(negedge clk);
            in_valid = 1'b0;
            chk(stall == 1'b0, "R4", "stall one cycle", 35'(stall), 35'(0));
        end
    endtask

    // Monitor: compare each issued result with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 unexpected result actual=%h expected=none", out_data);
            end else begin
                logic [34:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_data, out_narrow, out_hi_valid, out_lo_valid} == e, t, "result",
                    {out_data, out_narrow, out_hi_valid, out_lo_valid}, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_pack = 1'b0; in_lanes = 2'b00;
        in_op = 3'd0; in_a = 32'h0; in_b = 32'h0;
        repeat (3) @(negedge clk);
        chk({out_valid, out_narrow, out_lo_valid, out_hi_valid, stall, upper_gate} == 6'b0,
            "R9", "flags in reset", 35'({out_valid, out_narrow, out_lo_valid, out_hi_valid, stall, upper_gate}), 35'(0));
        chk(out_data == 32'h0, "R9", "data in reset", 35'(out_data), 35'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2: full-width operations and reserved codes.
        send(32'h1234_5678, 32'h0FED_CBA9, ADD,  1'b0, 2'b00, "R2");
        send(32'h8000_0000, 32'h0000_0001, SUB,  1'b0, 2'b00, "R2");
        send(32'hF0F0_1234, 32'h0FF0_FFFF, AND_, 1'b0, 2'b00, "R2");
        send(32'hA5A5_0000, 32'h0000_5A5A, OR_,  1'b0, 2'b00, "R2");
        send(32'hDEAD_BEEF, 32'hFFFF_0000, XOR_, 1'b0, 2'b00, "R2");
        send(32'h7654_3210, 32'h0123_4567, 3'd5, 1'b0, 2'b00, "R2");
        send(32'h0000_0003, 32'h0000_0004, 3'd7, 1'b0, 2'b00, "R2");

        // R1: narrowness boundaries at bit 15.
        send(32'h0000_8000, 32'h0000_0001, ADD, 1'b0, 2'b00, "R1");
        send(32'hFFFF_7FFF, 32'h0000_0001, ADD, 1'b0, 2'b00, "R1");
        send(32'h0000_7FFF, 32'h0001_0000, AND_, 1'b0, 2'b00, "R1");
        send(32'hFFFF_8000, 32'h0000_7FFF, OR_, 1'b0, 2'b00, "R1");

        // R3: gated operations with mixed signs.
        send(32'h0000_7FFF, 32'hFFFF_8000, ADD,  1'b0, 2'b00, "R3");
        send(32'hFFFF_FF9C, 32'h0000_0032, SUB,  1'b0, 2'b00, "R3");
        send(32'hFFFF_F0F0, 32'hFFFF_8F0F, XOR_, 1'b0, 2'b00, "R3");
        send(32'hFFFF_FFFF, 32'h0000_1234, AND_, 1'b0, 2'b00, "R3");

        // R4/R5: narrow overflow replays, back to back with narrow work.
        send(32'h0000_7FFF, 32'h0000_0001, ADD, 1'b0, 2'b00, "R4");
        send(32'h0000_0010, 32'h0000_0020, ADD, 1'b0, 2'b00, "R3");
        send(32'hFFFF_8000, 32'h0000_0001, SUB, 1'b0, 2'b00, "R4");
        send(32'h0000_4000, 32'hFFFF_C000, SUB, 1'b0, 2'b00, "R4");

        // R6: packed lanes, no carry or borrow across the boundary.
        send(32'h0001_FFFF, 32'h0001_0001, ADD,  1'b1, 2'b11, "R6");
        send(32'h0000_0000, 32'h0001_0001, SUB,  1'b1, 2'b11, "R6");
        send(32'h7FFF_7FFF, 32'h0001_0001, ADD,  1'b1, 2'b11, "R6");
        send(32'hF0F0_0F0F, 32'hFF00_00FF, XOR_, 1'b1, 2'b11, "R6");

        // R7: disabled lanes.
        send(32'h1111_2222, 32'h3333_4444, ADD, 1'b1, 2'b01, "R7");
        send(32'h1111_2222, 32'h3333_4444, ADD, 1'b1, 2'b10, "R7");
        send(32'h1111_2222, 32'h3333_4444, OR_, 1'b1, 2'b00, "R7");

        // R8: latency from an empty pipeline.
        repeat (4) @(negedge clk);
        send(32'h0000_0005, 32'h0000_0006, ADD, 1'b0, 2'b00, "R8");
        chk(out_valid == 1'b0, "R8", "valid one cycle after accept", 35'(out_valid), 35'(0));
        @(negedge clk);
        chk(out_valid == 1'b1, "R8", "valid two cycles after accept", 35'(out_valid), 35'(1));

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "results outstanding", 35'(exp_q.size()), 35'(0));
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule